// File: doc/BRIEF.md
# CAN Receive Message Buffer

This block is the receive store of a CAN controller. A frame engine, which has already checked bit timing and acceptance, streams each accepted frame into it one byte at a time: first a frame info byte, then the identifier bytes, then the data bytes. It closes the frame with a commit pulse when the frame is valid, or with an abort pulse when the frame is lost on the bus. The store holds 64 bytes in a circular buffer, so the number of frames it can hold depends on how long each frame is.

On the CPU side the oldest stored frame appears in a read window. The window is addressed by a byte offset from the start of that frame. A release command drops the oldest frame, and the next frame shows in the window on the following cycle. A message counter and two level flags, buffer-status and receive-interrupt, tell the CPU whether any frames are waiting. When a committed frame does not fit in the free space, the block rolls back every byte of it. The frame is never counted and never appears in the window. Instead the block raises a sticky overrun status bit and an overrun interrupt flag.

The input byte stream uses valid/ready. The block only withholds ready while reset mode is held, so it applies no back-pressure while it runs. Space is checked per byte: a byte that would overflow the store is taken from the stream but not written, and the frame is marked for drop.

Top module: `can_rx_msgbuf`

## Requirements
- R1: The store holds 64 bytes in total. Frames are kept as long as their bytes fit, so five 11-byte frames (55 bytes) fit, and a following 3-byte frame also fits.
- R2: The info byte encodes the frame: bit 7 set means extended format, bit 6 set means remote frame, and bits 3:0 hold the length code. A stored frame takes 3 header bytes (standard) or 5 header bytes (extended), plus min(length code, 8) data bytes. A remote frame has no data bytes.
- R3: A committed frame that does not fit in the free space is dropped whole. The message counter does not change, the frame never shows in the window, and the next frame is stored at the place where the dropped frame started.
- R4: A dropped frame sets both overrun_status and overrun_irq on the clock edge that takes the commit.
- R5: An irq_ack pulse clears overrun_irq. overrun_status stays set until a clr_overrun pulse. A new overrun in the same cycle as the clear takes priority.
- R6: msg_count goes up by one on each kept commit and down by one on each release. A release while msg_count is 0 has no effect.
- R7: A release moves the window past the oldest frame by its length (R2), and the next frame can be read from the next cycle.
- R8: buf_status and rx_irq are both high exactly when msg_count is nonzero.
- R9: win_data is the byte at (read pointer + win_off) modulo 64, so a frame that spans the top of the store reads out contiguously.
- R10: An abort pulse drops the open frame's bytes without any overrun and without counting the frame.
- R11: While reset_mode is high the store is emptied: the pointers, the open frame and msg_count are cleared, in_ready is low and commits are ignored.
- R12: A byte is taken only in a cycle where in_valid and in_ready are both high. Data on the bus while in_valid is low is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_mode | input | 1 | Controller reset mode; holds the store empty |
| in_valid | input | 1 | Frame byte valid |
| in_ready | output | 1 | Store can take a byte (low only in reset mode) |
| in_data | input | 8 | Frame byte |
| in_commit | input | 1 | Close the open frame as valid |
| in_abort | input | 1 | Close the open frame as lost |
| win_off | input | 6 | Byte offset into the current frame |
| win_data | output | 8 | Byte at that offset |
| rel_cmd | input | 1 | Release the current frame |
| clr_overrun | input | 1 | Clear the overrun status bit |
| irq_ack | input | 1 | Interrupt register read; clears the overrun interrupt |
| msg_count | output | 7 | Number of stored frames |
| buf_status | output | 1 | At least one frame stored |
| rx_irq | output | 1 | Receive interrupt |
| overrun_status | output | 1 | Sticky overrun status |
| overrun_irq | output | 1 | Overrun interrupt flag |

## Verification
Commit, abort, release and the flag commands each take effect on the one clock edge that samples them. So msg_count, the flags and the window contents are due one edge later. win_data follows win_off combinationally within that cycle. The bench drives every input on the falling edge and reads outputs on the next falling edge, which is exactly one rising edge after each stimulus. Window bytes are read a short settle delay after win_off changes. Each expected byte is rebuilt from the frame's info byte and a seed, using the length rule in R2.

// File: rtl/can_rxbuf_pkg.sv
package can_rxbuf_pkg;
  localparam int BYTE_W   = 8;
  localparam int LEN_W    = 5;
  localparam int HDR_STD  = 3;
  localparam int HDR_EXT  = 5;
  localparam int MAX_DATA = 8;

  // Stored length of a frame, decoded from its info byte.
  function automatic logic [LEN_W-1:0] frame_len(input logic [BYTE_W-1:0] info);
    logic [LEN_W-1:0] hdr;
    logic [LEN_W-1:0] dat;
    hdr = info[7] ? LEN_W'(HDR_EXT) : LEN_W'(HDR_STD);
    if (info[6])
      dat = '0;
    else if (info[3:0] > 4'(MAX_DATA))
      dat = LEN_W'(MAX_DATA);
    else
      dat = {1'b0, info[3:0]};
    return hdr + dat;
  endfunction
endpackage

// File: rtl/can_rxbuf_mem.sv
module can_rxbuf_mem #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] win_addr,
  output logic [DW-1:0] win_rdata,
  input  logic [AW-1:0] hdr_addr,
  output logic [DW-1:0] hdr_rdata
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign win_rdata = store[win_addr];
  assign hdr_rdata = store[hdr_addr];
endmodule

// File: rtl/can_rxbuf_wr.sv
module can_rxbuf_wr #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_commit,
  input  logic          in_abort,
  input  logic [AW:0]   used,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [DW-1:0] wdata,
  output logic          commit_ok,
  output logic [AW:0]   commit_len,
  output logic          drop_evt
);
  logic [AW-1:0] base_q;
  logic [AW:0]   cnt_q;
  logic          ovf_q;
  logic [AW+1:0] fill;
  logic          fire, fits;
  logic [AW:0]   cnt_n;
  logic          ovf_n;
  logic          closing;

  assign in_ready = !flush;
  assign fire     = in_valid && in_ready;
  assign fill     = {1'b0, used} + {1'b0, cnt_q};
  assign fits     = fill < (AW+2)'(DEPTH);
  assign we       = fire && fits;
  assign waddr    = base_q + cnt_q[AW-1:0];
  assign wdata    = in_data;
  assign cnt_n    = cnt_q + (AW+1)'(we);
  assign ovf_n    = ovf_q || (fire && !fits);
  assign closing  = (in_commit || in_abort) && !flush;

  assign commit_ok  = in_commit && !flush && !ovf_n && (cnt_n != '0);
  assign drop_evt   = in_commit && !flush && ovf_n;
  assign commit_len = cnt_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else if (flush) begin
      base_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else if (closing) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      if (commit_ok) base_q <= base_q + cnt_n[AW-1:0];
    end else begin
      cnt_q <= cnt_n;
      ovf_q <= ovf_n;
    end
  end

  // Committed plus open bytes never exceed the store.
  assert_fill_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= (AW+2)'(DEPTH));

  // A dropped frame leaves the frame start where it was.
  assert_drop_rollback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> base_q == $past(base_q));

  // An aborted frame neither counts nor overruns.
  assert_abort_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_abort && !in_commit) |-> !commit_ok && !drop_evt);
endmodule

// File: rtl/can_rxbuf_rd.sv
module can_rxbuf_rd #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          rel_cmd,
  input  logic          have_msg,
  input  logic [DW-1:0] hdr_byte,
  input  logic [AW-1:0] win_off,
  output logic [AW-1:0] hdr_addr,
  output logic [AW-1:0] win_addr,
  output logic          release_ok,
  output logic [AW:0]   release_len
);
  import can_rxbuf_pkg::*;

  logic [AW-1:0] rptr_q;

  assign hdr_addr    = rptr_q;
  assign win_addr    = rptr_q + win_off;
  assign release_ok  = rel_cmd && have_msg && !flush;
  assign release_len = (AW+1)'(frame_len(hdr_byte));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rptr_q <= '0;
    else if (flush)      rptr_q <= '0;
    else if (release_ok) rptr_q <= rptr_q + release_len[AW-1:0];
  end

  // A released frame's length is always a legal stored length.
  assert_len_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    release_ok |-> (release_len >= (AW+1)'(HDR_STD)) &&
                   (release_len <= (AW+1)'(HDR_EXT + MAX_DATA)));
endmodule

// File: rtl/can_rxbuf_occ.sv
module can_rxbuf_occ #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int MAX_MSGS = DEPTH / 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        commit_ok,
  input  logic [AW:0] commit_len,
  input  logic        release_ok,
  input  logic [AW:0] release_len,
  output logic [AW:0] used,
  output logic [AW:0] msg_cnt
);
  logic [AW:0] add_b, sub_b;

  assign add_b = commit_ok  ? commit_len  : '0;
  assign sub_b = release_ok ? release_len : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used    <= '0;
      msg_cnt <= '0;
    end else if (flush) begin
      used    <= '0;
      msg_cnt <= '0;
    end else begin
      used    <= used + add_b - sub_b;
      msg_cnt <= msg_cnt + (AW+1)'(commit_ok) - (AW+1)'(release_ok);
    end
  end

  // Counter cannot exceed the number of minimum-size frames.
  assert_count_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    msg_cnt <= (AW+1)'(MAX_MSGS));

  // No release is honoured on an empty store.
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    release_ok |-> msg_cnt != '0);

  // Empty counter and empty byte store go together.
  assert_empty_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_cnt == '0) == (used == '0));
endmodule

// File: rtl/can_rx_msgbuf.sv
module can_rx_msgbuf #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reset_mode,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_commit,
  input  logic          in_abort,
  input  logic [AW-1:0] win_off,
  output logic [DW-1:0] win_data,
  input  logic          rel_cmd,
  input  logic          clr_overrun,
  input  logic          irq_ack,
  output logic [AW:0]   msg_count,
  output logic          buf_status,
  output logic          rx_irq,
  output logic          overrun_status,
  output logic          overrun_irq
);
  logic          we;
  logic [AW-1:0] waddr;
  logic [DW-1:0] wdata;
  logic          commit_ok, drop_evt, release_ok;
  logic [AW:0]   commit_len, release_len, used;
  logic [AW-1:0] hdr_addr, win_addr;
  logic [DW-1:0] hdr_byte;

  can_rxbuf_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .win_addr(win_addr), .win_rdata(win_data),
    .hdr_addr(hdr_addr), .hdr_rdata(hdr_byte)
  );

  can_rxbuf_wr #(.DEPTH(DEPTH), .DW(DW)) u_wr (
    .clk(clk), .rst_n(rst_n), .flush(reset_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_commit(in_commit), .in_abort(in_abort), .used(used),
    .we(we), .waddr(waddr), .wdata(wdata),
    .commit_ok(commit_ok), .commit_len(commit_len), .drop_evt(drop_evt)
  );

  can_rxbuf_rd #(.DEPTH(DEPTH), .DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n), .flush(reset_mode),
    .rel_cmd(rel_cmd), .have_msg(msg_count != '0), .hdr_byte(hdr_byte),
    .win_off(win_off), .hdr_addr(hdr_addr), .win_addr(win_addr),
    .release_ok(release_ok), .release_len(release_len)
  );

  can_rxbuf_occ #(.DEPTH(DEPTH)) u_occ (
    .clk(clk), .rst_n(rst_n), .flush(reset_mode),
    .commit_ok(commit_ok), .commit_len(commit_len),
    .release_ok(release_ok), .release_len(release_len),
    .used(used), .msg_cnt(msg_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overrun_status <= 1'b0;
      overrun_irq    <= 1'b0;
    end else begin
      if (drop_evt)         overrun_status <= 1'b1;
      else if (clr_overrun) overrun_status <= 1'b0;
      if (drop_evt)         overrun_irq <= 1'b1;
      else if (irq_ack)     overrun_irq <= 1'b0;
    end
  end

  assign buf_status = msg_count != '0;
  assign rx_irq     = msg_count != '0;

  // A dropped frame does not move the counter.
  assert_drop_uncounted_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_evt && !release_ok && !reset_mode) |=> msg_count == $past(msg_count));

  // Overrun raises both flags.
  assert_overrun_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> overrun_status && overrun_irq);

  // Status survives an interrupt acknowledge.
  assert_status_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_status && !clr_overrun) |=> overrun_status);

  // Reset mode leaves the store empty.
  assert_flush_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reset_mode |=> msg_count == '0);
endmodule

// File: tb/sim_can_rx_msgbuf.sv
module sim_can_rx_msgbuf;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reset_mode = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       in_commit = 1'b0;
  logic       in_abort = 1'b0;
  logic [5:0] win_off = 6'd0;
  logic [7:0] win_data;
  logic       rel_cmd = 1'b0;
  logic       clr_overrun = 1'b0;
  logic       irq_ack = 1'b0;
  logic [6:0] msg_count;
  logic       buf_status, rx_irq, overrun_status, overrun_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  can_rx_msgbuf u0 (
    .clk(clk), .rst_n(rst_n), .reset_mode(reset_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_commit(in_commit), .in_abort(in_abort),
    .win_off(win_off), .win_data(win_data),
    .rel_cmd(rel_cmd), .clr_overrun(clr_overrun), .irq_ack(irq_ack),
    .msg_count(msg_count), .buf_status(buf_status), .rx_irq(rx_irq),
    .overrun_status(overrun_status), .overrun_irq(overrun_irq)
  );

  // info, seed
  localparam logic [15:0] VEC [8] = '{
    16'h0811, 16'h8422, 16'h4833, 16'hC344,
    16'h0F55, 16'h8866, 16'h0077, 16'h8288
  };

  function automatic int exp_len(input logic [7:0] info);
    int d;
    d = info[6] ? 0 : ((info[3:0] > 8) ? 8 : int'(info[3:0]));
    return (info[7] ? 5 : 3) + d;
  endfunction

  function automatic logic [7:0] fbyte(input logic [7:0] info, input logic [7:0] seed, input int k);
    return (k == 0) ? info : 8'(seed + 8'(k * 7));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [7:0] info, input logic [7:0] seed,
                            input int nbytes, input bit gaps, input bit abort_it);
    for (int k = 0; k < nbytes; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = fbyte(info, seed, k);
      if (gaps) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = 8'hEE;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    if (abort_it) in_abort = 1'b1; else in_commit = 1'b1;
    @(negedge clk);
    in_commit = 1'b0;
    in_abort  = 1'b0;
  endtask

  task automatic read_frame(input logic [7:0] info, input logic [7:0] seed, input string req);
    for (int k = 0; k < exp_len(info); k++) begin
      win_off = 6'(k);
      #1;
      chk(win_data == fbyte(info, seed, k), req, int'(win_data), int'(fbyte(info, seed, k)));
    end
  endtask

  task automatic do_release;
    @(negedge clk);
    rel_cmd = 1'b1;
    @(negedge clk);
    rel_cmd = 1'b0;
  endtask

  task automatic pulse_clr(input bit ack, input bit clr);
    @(negedge clk);
    irq_ack = ack;
    clr_overrun = clr;
    @(negedge clk);
    irq_ack = 1'b0;
    clr_overrun = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state (R8, R11)
    chk(msg_count == 0, "R6 reset count", int'(msg_count), 0);
    chk(!buf_status && !rx_irq, "R8 reset flags", int'(buf_status), 0);
    chk(!overrun_status && !overrun_irq, "R4 reset overrun", int'(overrun_status), 0);
    chk(in_ready, "R11 ready out of reset mode", int'(in_ready), 1);

    // Table walk: fill 62 bytes with mixed formats (R1, R2, R6)
    for (int i = 0; i < 8; i++) begin
      send_frame(VEC[i][15:8], VEC[i][7:0], exp_len(VEC[i][15:8]), 1'b0, 1'b0);
      chk(msg_count == 7'(i + 1), "R6 count up", int'(msg_count), i + 1);
    end
    chk(buf_status && rx_irq, "R8 flags with frames", int'(rx_irq), 1);
    chk(!overrun_status, "R1 mixed frames fit", int'(overrun_status), 0);
    for (int i = 0; i < 8; i++) begin
      read_frame(VEC[i][15:8], VEC[i][7:0], "R2 R7 frame bytes");
      do_release();
      chk(msg_count == 7'(7 - i), "R6 count down", int'(msg_count), 7 - i);
    end
    chk(!buf_status && !rx_irq, "R8 flags empty", int'(buf_status), 0);

    // Frame spanning the top of the store (R9)
    send_frame(8'h08, 8'hA0, 11, 1'b0, 1'b0);
    read_frame(8'h08, 8'hA0, "R9 wrapped window");
    do_release();

    // Overrun: five 11-byte frames fit, sixth dropped (R1, R3, R4)
    for (int i = 0; i < 5; i++) send_frame(8'h08, 8'(8'h10 * i), 11, 1'b0, 1'b0);
    chk(msg_count == 5, "R1 five frames", int'(msg_count), 5);
    send_frame(8'h08, 8'hF0, 11, 1'b0, 1'b0);
    chk(msg_count == 5, "R3 drop not counted", int'(msg_count), 5);
    chk(overrun_status, "R4 status set", int'(overrun_status), 1);
    chk(overrun_irq, "R4 irq set", int'(overrun_irq), 1);
    send_frame(8'h48, 8'hB0, 3, 1'b0, 1'b0);
    chk(msg_count == 6, "R1 small frame fits after drop", int'(msg_count), 6);
    pulse_clr(1'b1, 1'b0);
    chk(!overrun_irq, "R5 ack clears irq", int'(overrun_irq), 0);
    chk(overrun_status, "R5 status kept on ack", int'(overrun_status), 1);
    for (int i = 0; i < 5; i++) begin
      read_frame(8'h08, 8'(8'h10 * i), "R3 kept frames intact");
      do_release();
    end
    read_frame(8'h48, 8'hB0, "R3 dropped frame absent");
    do_release();
    pulse_clr(1'b0, 1'b1);
    chk(!overrun_status, "R5 clear command", int'(overrun_status), 0);

    // Release on empty store (R6)
    do_release();
    chk(msg_count == 0, "R6 release at zero", int'(msg_count), 0);
    chk(!buf_status, "R6 release at zero flags", int'(buf_status), 0);

    // Abort (R10)
    send_frame(8'h88, 8'hC0, 6, 1'b0, 1'b1);
    chk(msg_count == 0, "R10 abort uncounted", int'(msg_count), 0);
    chk(!overrun_status && !overrun_irq, "R10 abort no overrun", int'(overrun_irq), 0);
    send_frame(8'h04, 8'hD0, 7, 1'b0, 1'b0);
    read_frame(8'h04, 8'hD0, "R10 next frame at aborted start");
    do_release();

    // Idle cycles with junk data (R12)
    send_frame(8'h83, 8'h31, 8, 1'b1, 1'b0);
    chk(msg_count == 1, "R12 gapped frame counted", int'(msg_count), 1);
    read_frame(8'h83, 8'h31, "R12 junk not stored");
    do_release();

    // Reset mode (R11)
    send_frame(8'h02, 8'h41, 5, 1'b0, 1'b0);
    send_frame(8'h02, 8'h51, 5, 1'b0, 1'b0);
    chk(msg_count == 2, "R11 before reset mode", int'(msg_count), 2);
    @(negedge clk);
    reset_mode = 1'b1;
    @(negedge clk);
    chk(msg_count == 0, "R11 count cleared", int'(msg_count), 0);
    chk(!in_ready, "R11 ready low", int'(in_ready), 0);
    chk(!buf_status, "R11 store empty", int'(buf_status), 0);
    in_commit = 1'b1;
    @(negedge clk);
    in_commit = 1'b0;
    chk(msg_count == 0, "R11 commit ignored", int'(msg_count), 0);
    reset_mode = 1'b0;
    send_frame(8'h01, 8'h61, 4, 1'b0, 1'b0);
    chk(msg_count == 1, "R11 after reset mode", int'(msg_count), 1);
    read_frame(8'h01, 8'h61, "R11 pointers restarted");
    do_release();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule